// File: doc/BRIEF.md
# Two-Slot Instruction Fetch Sequencer

This block is the front end of a single-accumulator machine. Each 40-bit memory word holds two 20-bit instructions. Each instruction is an 8-bit opcode followed by a 12-bit operand address. The sequencer reads a word through a read port with a fixed latency and hands the left instruction to the execute stage. It keeps the right instruction in a one-slot buffer, so the next instruction needs no second read. A program counter advances by one word each time both halves of a word have been issued.

The execute stage takes instructions through a valid/ready handshake. When it meets a jump, it sends back a redirect: a target word address, a flag that picks the left or right half of that word, and a flag that makes the jump conditional on the accumulator sign. A redirect that is taken drops the buffered instruction. It also drops any instruction still on offer and any read still in flight, then fetches from the target. A conditional redirect with a negative accumulator does nothing.

Top module: `dual_fetch_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ex_valid` is low. The first read goes to word address 0, and the first instruction issued is the left half of word 0.
- R2: Within a word, the left instruction is bits 39:20 (opcode 39:32, address 31:20). The right instruction is bits 19:12 (opcode) and 11:0 (address).
- R3: A read is a single-cycle `mem_rd` pulse. The data is taken from `mem_data` exactly `RD_LAT` cycles later. The instruction is offered on `ex_valid` in the next cycle.
- R4: After a left-half fetch, the right half comes from the buffer with no memory read. Then the next sequential word is read, so two issued instructions cost one read.
- R5: A fetch that starts at a right half (after a jump to the right half) issues only that half and then reads the following word.
- R6: While `ex_valid` is high and `ex_ready` is low, `ex_valid`, `ex_op` and `ex_adr` hold. Each handshake retires exactly one instruction.
- R7: A taken redirect (`redir_valid` high, `redir_cond` low) drops the offered and the buffered instruction. `ex_valid` is low in the next cycle, and that same cycle starts a read at `redir_target`. The half then issued is the one picked by `redir_right` (1 = right).
- R8: A conditional redirect (`redir_cond` high) is taken only when `acc_neg` is 0. With `acc_neg` at 1 it has no effect, and the offered instruction stays in place.
- R9: A redirect taken while a read is outstanding discards that read's data. The instruction issued next comes from the target word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rd | output | 1 | Read request pulse |
| mem_addr | output | 12 | Word address of the read |
| mem_data | input | 40 | Read data, valid RD_LAT cycles after the request |
| ex_valid | output | 1 | Instruction offered to the execute stage |
| ex_ready | input | 1 | Execute stage accepts the offered instruction |
| ex_op | output | 8 | Opcode of the offered instruction |
| ex_adr | output | 12 | Operand address of the offered instruction |
| redir_valid | input | 1 | Redirect request |
| redir_cond | input | 1 | Redirect applies only if the accumulator is nonnegative |
| acc_neg | input | 1 | Accumulator sign (1 = negative) |
| redir_right | input | 1 | Redirect lands on the right half of the target word |
| redir_target | input | 12 | Target word address |

## Verification
The bench targets these corner cases:
- A redirect arriving in every phase of a fetch: while a read is issued, while its data is in flight, and while an instruction waits on a stalled execute stage. A design that forgot to cancel the in-flight read would issue the stale word.
- Jumps to the right half. A design that advanced the counter wrongly there would read the same word twice or skip one.
- Conditional jumps with a negative accumulator. A wrong design would flush the waiting instruction.
- Stalls with `ex_ready` low. A wrong design would change or lose the offered instruction.

A behavioural model predicts every read address and every offered instruction on each cycle.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  localparam int OPC_W  = 8;
  localparam int ADR_W  = 12;
  localparam int HALF_W = OPC_W + ADR_W;
  localparam int WORD_W = 2 * HALF_W;

  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic [ADR_W-1:0] adr;
  } instr_t;

  typedef enum logic [1:0] {PH_ISSUE, PH_WAIT, PH_HOLD} phase_t;

  // Left slot sits in the upper half of the bus, right slot in the lower half.
  function automatic instr_t slot_of(input logic [WORD_W-1:0] w, input logic pick_right);
    return pick_right ? instr_t'(w[HALF_W-1:0]) : instr_t'(w[WORD_W-1:HALF_W]);
  endfunction

  function automatic logic jump_taken(input logic req, input logic cond, input logic neg);
    return req && (!cond || !neg);
  endfunction
endpackage

// File: rtl/fseq_rd_timer.sv
module fseq_rd_timer #(
  parameter int RD_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic land
);
  localparam int CW = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;
  localparam logic [CW-1:0] LOAD_V = CW'(RD_LAT - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD_V;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign land = busy_q && (cnt_q == '0);
endmodule

// File: rtl/fseq_ibuf.sv
module fseq_ibuf
  import fseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clear,
  input  logic   load,
  input  instr_t load_val,
  input  logic   consume,
  output logic   valid,
  output instr_t slot
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      valid <= 1'b0;
      slot  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      slot  <= load_val;
    end else if (consume) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fseq_redirect.sv
module fseq_redirect
  import fseq_pkg::*;
(
  input  logic req,
  input  logic cond,
  input  logic neg,
  output logic take
);
  assign take = jump_taken(req, cond, neg);
endmodule

// File: rtl/dual_fetch_seq.sv
module dual_fetch_seq
  import fseq_pkg::*;
#(
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_rd,
  output logic [ADR_W-1:0]  mem_addr,
  input  logic [WORD_W-1:0] mem_data,
  output logic              ex_valid,
  input  logic              ex_ready,
  output logic [OPC_W-1:0]  ex_op,
  output logic [ADR_W-1:0]  ex_adr,
  input  logic              redir_valid,
  input  logic              redir_cond,
  input  logic              acc_neg,
  input  logic              redir_right,
  input  logic [ADR_W-1:0]  redir_target
);
  phase_t           phase_q;
  logic [ADR_W-1:0] pc_q;
  logic             right_q;
  logic [OPC_W-1:0] ir_q;
  logic [ADR_W-1:0] mar_q;

  // named internal events
  logic   redir_take;
  logic   rd_issue;
  logic   rd_land;
  logic   buf_use;
  logic   buf_valid;
  instr_t buf_slot;
  instr_t landed;

  fseq_redirect u_redir (
    .req  (redir_valid),
    .cond (redir_cond),
    .neg  (acc_neg),
    .take (redir_take)
  );

  assign rd_issue = (phase_q == PH_ISSUE) && !buf_valid;
  assign buf_use  = (phase_q == PH_ISSUE) &&  buf_valid;
  assign landed   = slot_of(mem_data, right_q);

  fseq_rd_timer #(.RD_LAT(RD_LAT)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (rd_issue && !redir_take),
    .abort (redir_take),
    .land  (rd_land)
  );

  fseq_ibuf u_ibuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (redir_take),
    .load     (rd_land && !right_q && (phase_q == PH_WAIT)),
    .load_val (slot_of(mem_data, 1'b1)),
    .consume  (buf_use),
    .valid    (buf_valid),
    .slot     (buf_slot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_ISSUE;
      pc_q    <= '0;
      right_q <= 1'b0;
      ir_q    <= '0;
      mar_q   <= '0;
    end else if (redir_take) begin
      phase_q <= PH_ISSUE;
      pc_q    <= redir_target;
      right_q <= redir_right;
    end else begin
      case (phase_q)
        PH_ISSUE: begin
          if (buf_valid) begin
            ir_q    <= buf_slot.opc;
            mar_q   <= buf_slot.adr;
            pc_q    <= pc_q + 1'b1;
            phase_q <= PH_HOLD;
          end else begin
            phase_q <= PH_WAIT;
          end
        end
        PH_WAIT: begin
          if (rd_land) begin
            ir_q  <= landed.opc;
            mar_q <= landed.adr;
            if (right_q) begin
              pc_q    <= pc_q + 1'b1;
              right_q <= 1'b0;
            end
            phase_q <= PH_HOLD;
          end
        end
        PH_HOLD: begin
          if (ex_ready) phase_q <= PH_ISSUE;
        end
        default: phase_q <= PH_ISSUE;
      endcase
    end
  end

  assign mem_rd   = rd_issue;
  assign mem_addr = pc_q;
  assign ex_valid = (phase_q == PH_HOLD);
  assign ex_op    = ir_q;
  assign ex_adr   = mar_q;
endmodule

// File: rtl/dual_fetch_seq_chk.sv
module dual_fetch_seq_chk
  import fseq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             mem_rd,
  input logic [ADR_W-1:0] mem_addr,
  input logic             ex_valid,
  input logic             ex_ready,
  input logic [OPC_W-1:0] ex_op,
  input logic [ADR_W-1:0] ex_adr,
  input logic             redir_valid,
  input logic             redir_cond,
  input logic             acc_neg,
  input logic [ADR_W-1:0] redir_target,
  input logic             redir_take,
  input logic             rd_land
);
  assert_single_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !redir_take) |=> !mem_rd);

  assert_land_offer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_land && !redir_take) |=> ex_valid);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && !ex_ready && !redir_take) |=> (ex_valid && $stable(ex_op) && $stable(ex_adr)));

  assert_redir_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redir_take |=> (mem_rd && (mem_addr == $past(redir_target))));

  assert_redir_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redir_take |=> !ex_valid);

  assert_cond_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && !ex_ready && redir_valid && redir_cond && acc_neg) |=> ex_valid);
endmodule

bind dual_fetch_seq dual_fetch_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_rd       (mem_rd),
  .mem_addr     (mem_addr),
  .ex_valid     (ex_valid),
  .ex_ready     (ex_ready),
  .ex_op        (ex_op),
  .ex_adr       (ex_adr),
  .redir_valid  (redir_valid),
  .redir_cond   (redir_cond),
  .acc_neg      (acc_neg),
  .redir_target (redir_target),
  .redir_take   (redir_take),
  .rd_land      (rd_land)
);

// File: tb/test_dual_fetch_seq.sv
module test_dual_fetch_seq;
  localparam int CLK_PER = 10;
  localparam int LAT     = 2;
  localparam int WDOG    = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_rd;
  logic [11:0] mem_addr;
  logic [39:0] mem_data;
  logic        ex_valid;
  logic        ex_ready = 1'b1;
  logic [7:0]  ex_op;
  logic [11:0] ex_adr;
  logic        rv = 1'b0, rc = 1'b0, an = 1'b0, rr = 1'b0;
  logic [11:0] rt = '0;

  always #(CLK_PER/2) clk = ~clk;

  dual_fetch_seq #(.RD_LAT(LAT)) i_dual_fetch_seq (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
    .ex_valid(ex_valid), .ex_ready(ex_ready), .ex_op(ex_op), .ex_adr(ex_adr),
    .redir_valid(rv), .redir_cond(rc), .acc_neg(an), .redir_right(rr), .redir_target(rt)
  );

  // word content: R2 layout {lop, ladr, rop, radr}
  function automatic logic [7:0]  lop(input logic [11:0] a);  return a[7:0] ^ 8'hA5; endfunction
  function automatic logic [11:0] ladr(input logic [11:0] a); return a + 12'h111; endfunction
  function automatic logic [7:0]  rop(input logic [11:0] a);  return a[7:0] + 8'h3C; endfunction
  function automatic logic [11:0] radr(input logic [11:0] a); return ~a; endfunction
  function automatic logic [39:0] memword(input logic [11:0] a);
    return {lop(a), ladr(a), rop(a), radr(a)};
  endfunction

  // memory with fixed latency
  logic [11:0] pa [LAT];
  always @(posedge clk) begin
    for (int i = LAT - 1; i > 0; i--) pa[i] <= pa[i-1];
    pa[0] <= mem_addr;
  end
  assign mem_data = memword(pa[LAT-1]);

  int total = 0, bad = 0, cyc = 0;
  bit stop = 0;
  string tag = "R1";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_pc, m_rdaddr, m_cnt, m_phase, m_op, m_adr, m_buf_op, m_buf_adr;
  bit m_buf_v, m_right;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_phase = 0; m_buf_v = 0; m_right = 0; m_cnt = 0;
    end else if (rv && (!rc || !an)) begin
      m_pc = rt; m_buf_v = 0; m_right = rr; m_phase = 0;
    end else if (m_phase == 0) begin
      if (m_buf_v) begin
        m_op = m_buf_op; m_adr = m_buf_adr; m_buf_v = 0;
        m_pc = (m_pc + 1) % 4096; m_phase = 2;
      end else begin
        m_rdaddr = m_pc; m_cnt = LAT - 1; m_phase = 1;
      end
    end else if (m_phase == 1) begin
      if (m_cnt == 0) begin
        if (m_right) begin
          m_op = rop(12'(m_rdaddr)); m_adr = radr(12'(m_rdaddr));
          m_pc = (m_pc + 1) % 4096; m_right = 0;
        end else begin
          m_op = lop(12'(m_rdaddr)); m_adr = ladr(12'(m_rdaddr));
          m_buf_op = rop(12'(m_rdaddr)); m_buf_adr = radr(12'(m_rdaddr)); m_buf_v = 1;
        end
        m_phase = 2;
      end else m_cnt--;
    end else if (ex_ready) m_phase = 0;
  end

  always @(negedge clk) begin
    if (rst_n && !stop) begin
      chk(mem_rd == (m_phase == 0 && !m_buf_v), tag, "mem_rd", mem_rd, (m_phase == 0 && !m_buf_v));
      if (m_phase == 0 && !m_buf_v) chk(mem_addr == 12'(m_pc), tag, "mem_addr", mem_addr, m_pc);
      chk(ex_valid == (m_phase == 2), tag, "ex_valid", ex_valid, (m_phase == 2));
      if (m_phase == 2) begin
        chk(ex_op == 8'(m_op), tag, "ex_op", ex_op, m_op);
        chk(ex_adr == 12'(m_adr), tag, "ex_adr", ex_adr, m_adr);
      end
    end
  end

  // handshake and read monitor
  logic [19:0] acc_q[$];
  logic [11:0] rd_q[$];
  always @(posedge clk) begin
    if (rst_n) begin
      if (ex_valid && ex_ready && !(rv && (!rc || !an))) acc_q.push_back({ex_op, ex_adr});
      if (mem_rd) rd_q.push_back(mem_addr);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !stop) begin
      stop = 1;
      chk(0, "R3", "watchdog cycles", cyc, WDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; rv = 0; ex_ready = 1;
    repeat (3) @(negedge clk);
    acc_q.delete(); rd_q.delete();
    rst_n = 1'b1;
  endtask

  task automatic jump(input logic [11:0] t, input logic right, input logic cond, input logic neg);
    rt = t; rr = right; rc = cond; an = neg; rv = 1'b1;
    @(negedge clk);
    rv = 1'b0; rc = 1'b0; an = 1'b0;
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    do_reset();
    chk(ex_valid == 0, "R1", "ex_valid after reset", ex_valid, 0);
    chk(mem_rd == 1 && mem_addr == 0, "R1", "first read addr", mem_addr, 0);
    for (int i = 0; i < 40 && acc_q.size() < 4; i++) @(negedge clk);
    // R2 and R4: left then right of word 0, two reads for four instructions
    tag = "R4";
    chk(acc_q.size() >= 4, "R4", "accepted count", acc_q.size(), 4);
    if (acc_q.size() >= 4) begin
      chk(acc_q[0] == {lop(0), ladr(0)}, "R2", "left slot word0", acc_q[0], {lop(0), ladr(0)});
      chk(acc_q[1] == {rop(0), radr(0)}, "R2", "right slot word0", acc_q[1], {rop(0), radr(0)});
      chk(acc_q[3] == {rop(1), radr(1)}, "R2", "right slot word1", acc_q[3], {rop(1), radr(1)});
    end
    chk(rd_q.size() == 2, "R4", "reads for four instr", rd_q.size(), 2);

    // R3 and R7: unconditional jump to left half, count latency
    tag = "R7";
    ex_ready = 0;
    while (!ex_valid) @(negedge clk);
    jump(12'h040, 1'b0, 1'b0, 1'b0);
    chk(ex_valid == 0, "R7", "offer dropped", ex_valid, 0);
    chk(mem_rd && mem_addr == 12'h040, "R7", "read at target", mem_addr, 12'h040);
    ex_ready = 1;
    for (int i = 1; i <= LAT; i++) begin
      @(negedge clk);
      chk(ex_valid == 0, "R3", "not yet offered", ex_valid, 0);
    end
    @(negedge clk);
    chk(ex_valid == 1 && ex_op == lop(12'h040), "R3", "offer after latency", ex_op, lop(12'h040));

    // R5: jump to right half, next read at target+1
    tag = "R5";
    jump(12'h205, 1'b1, 1'b0, 1'b0);
    repeat (LAT + 1) @(negedge clk);
    chk(ex_valid && ex_op == rop(12'h205) && ex_adr == radr(12'h205), "R5", "right slot op", ex_op, rop(12'h205));
    @(negedge clk);
    chk(mem_rd && mem_addr == 12'h206, "R5", "next word read", mem_addr, 12'h206);

    // R6 and R8: stall, conditional jump with negative accumulator ignored
    tag = "R8";
    ex_ready = 0;
    while (!ex_valid) @(negedge clk);
    jump(12'h3A0, 1'b0, 1'b1, 1'b1);
    chk(ex_valid && ex_op == lop(12'h206), "R8", "ignored jump keeps offer", ex_op, lop(12'h206));
    repeat (3) @(negedge clk);
    chk(ex_valid && ex_adr == ladr(12'h206), "R6", "stall holds", ex_adr, ladr(12'h206));
    jump(12'h3A0, 1'b0, 1'b1, 1'b0);
    chk(mem_rd && mem_addr == 12'h3A0, "R8", "taken cond jump", mem_addr, 12'h3A0);
    ex_ready = 1;

    // R9: redirect while a read is in flight
    tag = "R9";
    @(negedge clk);
    jump(12'h300, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    jump(12'h310, 1'b0, 1'b0, 1'b0);
    repeat (LAT + 1) @(negedge clk);
    chk(ex_valid && ex_op == lop(12'h310), "R9", "stale read discarded", ex_op, lop(12'h310));

    // R6/R7/R8 mixed traffic, redirects at every phase offset
    tag = "R6";
    for (int i = 0; i < 600; i++) begin
      ex_ready = (i % 3) != 0;
      if (i % 13 == 5) jump(12'(i * 7), i[0], i[1], i[2]);
      else @(negedge clk);
    end
    stop = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule